// File: doc/BRIEF.md
# Multi-Mode Timer Pair

This block holds two independent 32-bit timers that share one counter datapath design and one control/status word. Each timer owns a single pin, presented as an input, an output and an output-enable, and is programmed into one of three modes. In generation mode it drives a periodic pulse whose period and active width come from registers. In capture mode it measures an incoming pulse, recording both its active width and its full period. In event-watchdog mode it counts pin edges and flags when a programmed count is reached.

Software reaches the block through a simple register port: a one-cycle write strobe with address and data, and a combinational read path. Each timer has a configuration register, a count register, a period register and a width register. A shared control word holds the run enables, the sticky event flags and the sticky error flags. Both flag sets are cleared by writing 1. One interrupt line ORs together the enabled event flags. A debug-halt input freezes any timer whose configuration does not allow it to run while halted.

Top module: `gpt_pair`

## Requirements
- R1: After reset every register reads 0, every pin output and output-enable is 0, and the interrupt is low.
- R2: In generation mode (mode field 01) with period P >= 2 and width W, the count runs 0..P-1. The pin is active while count < W and inactive from W to P-1. When the count is P-1 it reloads to 0 and sets that timer's event flag.
- R3: Config bit 2 inverts the pin. In generation mode the active level becomes low, and the idle level of a disabled timer equals the bit.
- R4: In capture mode (mode field 10) an active pin edge (rising, or falling when bit 2 is set) clears the count. The following opposite edge stores the pulse length in cycles into the width register. The next active edge stores the edge-to-edge length into the period register and sets the event flag.
- R5: In watchdog mode (mode field 11) each active pin edge adds one to the count, and nothing else moves it. When the count would reach the period, it returns to 0 and sets the event flag.
- R6: The pin output-enable is 1 only while the timer is enabled in generation mode.
- R7: In generation or watchdog mode, a period below 2 sets that timer's error flag and the count holds.
- R8: In the control word (address 4*NTIM), bits [NTIM-1:0] are the enables and are written as given. Bits [2*NTIM-1:NTIM] are the event flags and bits [3*NTIM-1:2*NTIM] are the error flags; writing 1 clears a flag, and a new event in the same cycle wins.
- R9: The interrupt output is high when any timer has its event flag set and config bit 3 set.
- R10: While the debug-halt input is high, a timer with config bit 4 clear keeps its count. With bit 4 set, it keeps counting.
- R11: The timers are independent: running one leaves the other's count and pin unchanged.
- R12: Timer t's registers sit at address 4t (config), 4t+1 (count), 4t+2 (period) and 4t+3 (width). Config bit 5 is reserved and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_halt | input | 1 | Debug halt request |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | AW | Write address |
| reg_wdata | input | CW | Write data |
| reg_raddr | input | AW | Read address |
| reg_rdata | output | CW | Read data (combinational) |
| tmr_pin_in | input | NTIM | Pin input level per timer |
| tmr_pin_out | output | NTIM | Pin output level per timer |
| tmr_pin_oe | output | NTIM | Pin output-enable per timer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with two timers and a 16-bit counter, so the control word sits at address 8. Short periods of 3 to 10 cycles bring a full generation period, a capture of a 4-cycle pulse in a 10-cycle period, and a watchdog expiry within a few dozen cycles. With two timers, the tests can run one timer while checking that the other stays unchanged, and the flag bits of both timers can be checked in the same control word.

// File: rtl/gpt_pkg.sv
// Shared definitions for the timer pair: mode encoding and config bit positions.
package gpt_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_WDOG = 2'b11
    } gpt_mode_e;

    localparam int CFG_W    = 6;  // architectural config width, top bit reserved
    localparam int CFG_POL  = 2;
    localparam int CFG_IE   = 3;
    localparam int CFG_EMU  = 4;
endpackage

// File: rtl/gpt_edge.sv
// Pin input synchronizer and edge detector.
// Assumes an asynchronous pin level; two flops resolve it, a third gives the
// previous level. Polarity selects which edge counts as the active one.
module gpt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic pol,
    output logic act_edge,
    output logic end_edge
);
    logic s1, s2, s3;
    logic lvl, prv;

    // synchronize the pin and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin_raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // polarity-adjusted levels and edge pulses
    always_comb begin
        lvl      = s2 ^ pol;
        prv      = s3 ^ pol;
        act_edge = lvl & ~prv;
        end_edge = ~lvl & prv;
    end
endmodule

// File: rtl/gpt_core.sv
// Counter datapath of one timer, shared by generation, capture and watchdog modes.
// Assumes period/width/mode are stable register values from the top and that
// edge pulses come from gpt_edge already adjusted for polarity.
module gpt_core
    import gpt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  gpt_mode_e     mode,
    input  logic          pol,
    input  logic          freeze,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] width,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          act_edge,
    input  logic          end_edge,
    output logic [CW-1:0] cnt,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          tick,
    output logic          fault,
    output logic          cap_w_vld,
    output logic          cap_p_vld,
    output logic [CW-1:0] cap_val
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] cnt_nx;
    logic          armed, armed_nx;
    logic          run, bad_per, uses_per;

    // next-state selection for the shared counter
    always_comb begin
        run       = en && !freeze;
        bad_per   = period < TWO;
        uses_per  = (mode == MODE_GEN) || (mode == MODE_WDOG);
        cnt_nx    = cnt;
        armed_nx  = armed;
        tick      = 1'b0;
        fault     = 1'b0;
        cap_w_vld = 1'b0;
        cap_p_vld = 1'b0;
        cap_val   = cnt + ONE;
        if (!en || mode != MODE_CAP) armed_nx = 1'b0;
        if (run) begin
            unique case (mode)
                MODE_GEN: begin
                    if (bad_per) fault = 1'b1;
                    else if (cnt >= period - ONE) begin
                        cnt_nx = '0;
                        tick   = 1'b1;
                    end else cnt_nx = cnt + ONE;
                end
                MODE_CAP: begin
                    if (act_edge) begin
                        cnt_nx    = '0;
                        cap_p_vld = armed;
                        tick      = armed;
                        armed_nx  = 1'b1;
                    end else begin
                        cnt_nx    = cnt + ONE;
                        cap_w_vld = end_edge && armed;
                    end
                end
                MODE_WDOG: begin
                    if (bad_per) fault = 1'b1;
                    else if (act_edge) begin
                        if (cnt + ONE >= period) begin
                            cnt_nx = '0;
                            tick   = 1'b1;
                        end else cnt_nx = cnt + ONE;
                    end
                end
                default: ;
            endcase
        end
        if (cnt_wr) cnt_nx = cnt_wdata;
    end

    // counter and capture-arm state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            armed <= armed_nx;
        end
    end

    // pin drive: active phase while below width, idle level follows polarity
    always_comb begin
        pin_oe  = en && (mode == MODE_GEN);
        pin_out = pin_oe ? ((cnt < width) ^ pol) : pol;
    end

    // R2
    gen_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && mode == MODE_GEN && !bad_per && !cnt_wr && cnt == period - ONE |=> cnt == '0);
    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && uses_per && bad_per && !cnt_wr |=> $stable(cnt));
    // R5
    wdog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && mode == MODE_WDOG && !act_edge && !cnt_wr |=> $stable(cnt));
    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && freeze && !cnt_wr |=> $stable(cnt));
endmodule

// File: rtl/gpt_pair.sv
// Two-timer block: per-timer config/period/width registers, shared control word
// with write-1-to-clear flags, read mux and interrupt merge.
// Assumes single-cycle register writes; reads are combinational.
module gpt_pair
    import gpt_pkg::*;
#(
    parameter int  NTIM = 2,
    parameter int  CW   = 32,
    localparam int AW   = $clog2(NTIM * 4 + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_halt,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_waddr,
    input  logic [CW-1:0]   reg_wdata,
    input  logic [AW-1:0]   reg_raddr,
    output logic [CW-1:0]   reg_rdata,
    input  logic [NTIM-1:0] tmr_pin_in,
    output logic [NTIM-1:0] tmr_pin_out,
    output logic [NTIM-1:0] tmr_pin_oe,
    output logic            irq
);
    localparam int          CS    = CFG_W - 1;  // stored config bits
    localparam logic [AW-1:0] CTL_A = AW'(NTIM * 4);

    logic [NTIM-1:0]          en_q, evt_q, err_q;
    logic [NTIM-1:0]          tick_v, fault_v, ie_v;
    logic [NTIM-1:0][CS-1:0]  cfg_v;
    logic [NTIM-1:0][CW-1:0]  cnt_v, per_v, wid_v;
    logic                     ctl_wr;

    assign ctl_wr = reg_wr && (reg_waddr == CTL_A);

    for (genvar g = 0; g < NTIM; g++) begin : g_tim
        logic [CS-1:0] cfg_q;
        logic [CW-1:0] per_q, wid_q, cap_val;
        logic          act_e, end_e, cap_w, cap_p;

        // per-timer register file with capture results taking priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
                per_q <= '0;
                wid_q <= '0;
            end else begin
                if (reg_wr && reg_waddr == AW'(g * 4)) cfg_q <= reg_wdata[CS-1:0];
                if (cap_p) per_q <= cap_val;
                else if (reg_wr && reg_waddr == AW'(g * 4 + 2)) per_q <= reg_wdata;
                if (cap_w) wid_q <= cap_val;
                else if (reg_wr && reg_waddr == AW'(g * 4 + 3)) wid_q <= reg_wdata;
            end
        end

        gpt_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (tmr_pin_in[g]),
            .pol      (cfg_q[CFG_POL]),
            .act_edge (act_e),
            .end_edge (end_e)
        );

        gpt_core #(.CW(CW)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_q[g]),
            .mode      (gpt_mode_e'(cfg_q[1:0])),
            .pol       (cfg_q[CFG_POL]),
            .freeze    (dbg_halt && !cfg_q[CFG_EMU]),
            .period    (per_q),
            .width     (wid_q),
            .cnt_wr    (reg_wr && reg_waddr == AW'(g * 4 + 1)),
            .cnt_wdata (reg_wdata),
            .act_edge  (act_e),
            .end_edge  (end_e),
            .cnt       (cnt_v[g]),
            .pin_out   (tmr_pin_out[g]),
            .pin_oe    (tmr_pin_oe[g]),
            .tick      (tick_v[g]),
            .fault     (fault_v[g]),
            .cap_w_vld (cap_w),
            .cap_p_vld (cap_p),
            .cap_val   (cap_val)
        );

        assign cfg_v[g] = cfg_q;
        assign per_v[g] = per_q;
        assign wid_v[g] = wid_q;
        assign ie_v[g]  = cfg_q[CFG_IE];
    end

    // shared control word: enables written directly, flags set by events, W1C
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            evt_q <= '0;
            err_q <= '0;
        end else if (ctl_wr) begin
            en_q  <= reg_wdata[NTIM-1:0];
            evt_q <= (evt_q & ~reg_wdata[2*NTIM-1:NTIM]) | tick_v;
            err_q <= (err_q & ~reg_wdata[3*NTIM-1:2*NTIM]) | fault_v;
        end else begin
            evt_q <= evt_q | tick_v;
            err_q <= err_q | fault_v;
        end
    end

    // combinational read mux over the address map
    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == CTL_A) reg_rdata = CW'({err_q, evt_q, en_q});
        for (int t = 0; t < NTIM; t++) begin
            if (reg_raddr == AW'(t * 4))     reg_rdata = CW'(cfg_v[t]);
            if (reg_raddr == AW'(t * 4 + 1)) reg_rdata = cnt_v[t];
            if (reg_raddr == AW'(t * 4 + 2)) reg_rdata = per_v[t];
            if (reg_raddr == AW'(t * 4 + 3)) reg_rdata = wid_v[t];
        end
    end

    assign irq = |(evt_q & ie_v);

    // R8
    w1c_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && reg_wdata[NTIM] && !tick_v[0] |=> !evt_q[0]);
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt_q & ie_v) != '0);
endmodule

// File: tb/gpt_pair_test.sv
// Scoreboard bench: the driver queues expected items, the monitor checks them on falling edges.
module gpt_pair_test;
    localparam int NT = 2;
    localparam int CW = 16;
    localparam int AW = $clog2(NT * 4 + 1);
    localparam int CTL = NT * 4;

    logic clk = 1'b0, rst_n = 1'b0, dbg_halt = 1'b0, reg_wr = 1'b0;
    logic [AW-1:0] reg_waddr = '0, reg_raddr = '0;
    logic [CW-1:0] reg_wdata = '0, reg_rdata;
    logic [NT-1:0] tmr_pin_in = '0, tmr_pin_out, tmr_pin_oe;
    logic irq;

    typedef struct {
        string       req;
        int          kind;  // 0 register, 1 pin out, 2 pin oe, 3 irq
        int          idx;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0, fails = 0;
    bit done = 1'b0;

    gpt_pair #(.NTIM(NT), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .reg_wr(reg_wr),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata), .tmr_pin_in(tmr_pin_in), .tmr_pin_out(tmr_pin_out),
        .tmr_pin_oe(tmr_pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    // monitor: one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.kind == 0) reg_raddr = AW'(it.idx);
                #1;
                case (it.kind)
                    0: act = 32'(reg_rdata);
                    1: act = 32'(tmr_pin_out[it.idx]);
                    2: act = 32'(tmr_pin_oe[it.idx]);
                    default: act = 32'(irq);
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string r, input int k, input int i, input logic [31:0] e);
        item_t it;
        it.req = r; it.kind = k; it.idx = i; it.exp = e;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        reg_wr = 1'b1; reg_waddr = AW'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse1();
        tmr_pin_in[1] = 1'b1; idle(2);
        tmr_pin_in[1] = 1'b0; idle(2);
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1; #0;
        idle(1);
        // R1 reset state
        push("R1", 0, CTL, 0); push("R1", 0, 1, 0); push("R1", 0, 0, 0);
        push("R1", 1, 0, 0);   push("R1", 2, 0, 0); push("R1", 3, 0, 0);
        drain();

        // R12 reserved config bit reads 0
        wr(0, 16'h3F);
        push("R12", 0, 0, 32'h1F);
        drain();

        // R2 generation: period 5, width 2
        wr(2, 5); wr(3, 2); wr(1, 0); wr(0, 16'h09);
        push("R6", 2, 0, 0);
        drain();
        wr(CTL, 1);
        push("R2", 1, 0, 1); push("R2", 1, 0, 1); push("R2", 1, 0, 0);
        push("R2", 1, 0, 0); push("R2", 1, 0, 0); push("R2", 1, 0, 1);
        push("R2", 1, 0, 1); push("R2", 1, 0, 0); push("R2", 1, 0, 0);
        push("R2", 1, 0, 0);
        push("R6", 2, 0, 1);
        push("R9", 3, 0, 1);
        push("R2", 0, CTL, 32'h5);
        push("R11", 0, 5, 0); push("R11", 2, 1, 0); push("R11", 1, 1, 0);
        drain();
        wr(CTL, 0); wr(CTL, 16'h4);
        push("R8", 0, CTL, 0); push("R9", 3, 0, 0); push("R6", 2, 0, 0);
        drain();

        // R3 inverted polarity
        wr(1, 0); wr(0, 16'h05);
        push("R3", 1, 0, 1);
        drain();
        wr(CTL, 1);
        push("R3", 1, 0, 0); push("R3", 1, 0, 0); push("R3", 1, 0, 1);
        push("R3", 1, 0, 1); push("R3", 1, 0, 1); push("R3", 1, 0, 0);
        drain();
        wr(CTL, 0); wr(CTL, 16'h4); wr(0, 0);

        // R4 capture on timer 1: 4-cycle pulse in a 10-cycle period
        wr(4, 16'h0A); wr(CTL, 2); idle(3);
        tmr_pin_in[1] = 1'b1; idle(4);
        tmr_pin_in[1] = 1'b0; idle(6);
        tmr_pin_in[1] = 1'b1; idle(6);
        push("R4", 0, 7, 4); push("R4", 0, 6, 10);
        push("R4", 0, CTL, 32'hA); push("R9", 3, 0, 1);
        drain();
        wr(CTL, 0); wr(CTL, 16'h8);
        tmr_pin_in[1] = 1'b0; idle(4);

        // R5 watchdog on timer 1, interrupt enable off
        wr(6, 3); wr(5, 0); wr(4, 16'h03); wr(CTL, 2);
        pulse1(); pulse1(); idle(3);
        push("R5", 0, 5, 2); push("R5", 0, CTL, 32'h2);
        drain();
        pulse1(); idle(3);
        push("R5", 0, 5, 0); push("R5", 0, CTL, 32'hA); push("R9", 3, 0, 0);
        drain();
        wr(CTL, 0); wr(CTL, 16'h8);

        // R7 bad period on timer 0
        wr(2, 1); wr(1, 7); wr(0, 16'h01); wr(CTL, 1); idle(4);
        push("R7", 0, 1, 7); push("R7", 0, CTL, 32'h11);
        drain();
        wr(CTL, 0); wr(CTL, 16'h10);
        push("R8", 0, CTL, 0);
        drain();

        // R10 debug halt freezes unless the emulation bit is set
        wr(2, 100); wr(3, 0); wr(1, 0); wr(0, 16'h01);
        dbg_halt = 1'b1;
        wr(CTL, 1); idle(5);
        push("R10", 0, 1, 0);
        drain();
        wr(0, 16'h11); idle(5);
        push("R10", 0, 1, 5);
        drain();
        dbg_halt = 1'b0;
        wr(CTL, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule